// File: doc/BRIEF.md
# Interrupt Destination Arbiter

This block takes one interrupt command and works out which of N processor agents it reaches. The command comes as two 32-bit words. The low word carries the vector, delivery mode, addressing mode, level, trigger and shorthand. The high word carries the 8-bit destination. Each agent describes itself on side-band inputs:
- its physical ID,
- its logical ID,
- a 2-bit logical format code,
- a present flag,
- an enable flag.

The sender is named by an index.

One cycle after a `cmd_valid` strobe the block presents a registered delivery mask and a copy of the command, along with a single-cycle `done` pulse. Fixed delivery may target many agents at once. Lowest-priority delivery does not compare priorities. It hands the interrupt to one eligible agent, picked by a rotating search that remembers the last winner. The downstream fabric uses the mask to deliver the interrupt.

Top module: `irq_dest_arbiter`

## Requirements
- R1: After reset, `done` is 0 and `deliver_mask` is all zero. The rotation pointer starts at agent N-1, so the first lowest-priority search begins at agent 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `cmd_valid` high, and 0 otherwise. `deliver_mask` and `cmd_echo` change only at that edge.
- R3: The shorthand field is low-word bits 19:18. 0 uses the destination. 1 selects only the sender (`src_sel`). 2 selects every agent. 3 selects every agent except the sender.
- R4: With shorthand 0 and low-word bit 11 = 0 (physical), an agent matches when the destination (high-word bits 31:24) equals its physical ID, or when the destination is 0xFF.
- R5: With shorthand 0 and bit 11 = 1 (logical), an agent with format code 0 (flat) matches when its logical ID AND the destination is non-zero.
- R6: In logical mode, an agent with format code 1 (cluster) matches when the upper nibbles of its logical ID and the destination are equal and the lower nibbles share a set bit. Format codes 2 and 3 never match in logical mode.
- R7: Delivery mode is low-word bits 10:8. In mode 0 (fixed) the mask is every agent that matches, is present and is enabled.
- R8: In mode 1 (lowest priority) the candidates are the agents that match, are present and are enabled. The search starts at the agent after the pointer and wraps. The first candidate found is the only bit set in the mask, and the pointer moves to it.
- R9: In mode 1 with no candidate, the mask is zero and the pointer does not move.
- R10: In modes 2 to 7 the mask is every agent that matches and is present. Enable has no effect.
- R11: `cmd_echo` equals the low word with bit 12 (delivery status) forced to 0. `vector` is bits 7:0, `dlv_mode` is bits 10:8, `level` is bit 14 and `trig` is bit 15 of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_lo | input | 32 | Low command word: vector, mode, addressing, level, trigger, shorthand |
| cmd_hi | input | 32 | High command word, destination in bits 31:24 |
| src_sel | input | SW | Index of the sending agent |
| agent_phys_id | input | N*8 | Physical ID of each agent, agent a in bits 8a+7:8a |
| agent_log_id | input | N*8 | Logical ID of each agent |
| agent_fmt | input | N*2 | Logical format code of each agent (0 flat, 1 cluster) |
| agent_present | input | N | Agent exists |
| agent_enable | input | N | Agent accepts fixed and lowest-priority interrupts |
| done | output | 1 | Result valid pulse |
| deliver_mask | output | N | Agents to deliver to |
| cmd_echo | output | 32 | Stored low word, status bit cleared |
| vector | output | 8 | Vector of the stored command |
| dlv_mode | output | 3 | Delivery mode of the stored command |
| level | output | 1 | Level bit of the stored command |
| trig | output | 1 | Trigger bit of the stored command |

## Verification
The bench sweeps every destination value against every shorthand, both addressing modes, three delivery modes and two senders, over two agent configurations. The configurations mix flat, cluster and unrecognised formats with absent and disabled agents. The 0xFF broadcast and nibble-boundary cluster cases are where a wrong design would drop agents, or match agents whose lower nibbles share no bit. A wrong rotation shows up as a winner that repeats, or that skips the agent after the last one. An arbiter that moves its pointer on an empty candidate set shows up in the next winner. A design that lets enable gate non-fixed modes, or that lets absent agents through on broadcast, produces a mask that differs from the bench's arithmetic model.

// File: rtl/ida_pkg.sv
package ida_pkg;
    localparam int ID_W       = 8;
    localparam int FMT_W      = 2;
    localparam int SH_LO      = 18;
    localparam int ADDR_BIT   = 11;
    localparam int MODE_LO    = 8;
    localparam int STATUS_BIT = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int TRIG_BIT   = 15;
    localparam int DEST_LO    = 24;

    localparam logic [ID_W-1:0] BCAST_ID = 8'hFF;

    localparam logic [2:0] MODE_FIXED  = 3'd0;
    localparam logic [2:0] MODE_LOWEST = 3'd1;

    localparam logic [FMT_W-1:0] FMT_FLAT    = 2'd0;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 2'd1;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;
endpackage

// File: rtl/ida_match.sv
module ida_match
    import ida_pkg::*;
(
    input  shorthand_e        sh,
    input  logic              logical,
    input  logic [ID_W-1:0]   dest,
    input  logic [ID_W-1:0]   phys_id,
    input  logic [ID_W-1:0]   log_id,
    input  logic [FMT_W-1:0]  fmt,
    input  logic              is_src,
    input  logic              present,
    output logic              hit
);
    localparam int NIB = ID_W / 2;

    logic flat_hit;
    logic clus_hit;
    logic log_hit;
    logic phys_hit;
    logic sel;

    always_comb begin
        flat_hit = |(log_id & dest);
        clus_hit = (log_id[ID_W-1:NIB] == dest[ID_W-1:NIB]) &&
                   (|(log_id[NIB-1:0] & dest[NIB-1:0]));
        case (fmt)
            FMT_FLAT:    log_hit = flat_hit;
            FMT_CLUSTER: log_hit = clus_hit;
            default:     log_hit = 1'b0;
        endcase
        phys_hit = (dest == BCAST_ID) || (dest == phys_id);
        case (sh)
            SH_DEST:   sel = logical ? log_hit : phys_hit;
            SH_SELF:   sel = is_src;
            SH_ALL:    sel = 1'b1;
            SH_OTHERS: sel = !is_src;
            default:   sel = 1'b0;
        endcase
        hit = sel && present;
    end
endmodule

// File: rtl/ida_rr_pick.sv
module ida_rr_pick #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] cand,
    output logic [N-1:0] grant
);
    typedef struct packed {
        logic [SW-1:0] last;
    } rr_state_t;

    localparam logic [SW-1:0] LAST_RST = SW'(N - 1);

    rr_state_t st_d, st_q;
    logic      found;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(st_q.last) + 1 + k;
            if (idx >= N) idx = idx - N;
            if (!found && cand[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                if (fire) st_d.last = SW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: LAST_RST};
        else        st_q <= st_d;
    end

    p_grant_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((grant & ~cand) == '0 && $onehot0(grant)));
    p_grant_some_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cand != '0)) |-> (grant != '0));
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cand == '0)) |=> $stable(st_q.last));
    p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(st_q.last));
endmodule

// File: rtl/irq_dest_arbiter.sv
module irq_dest_arbiter
    import ida_pkg::*;
#(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [31:0]        cmd_lo,
    input  logic [31:0]        cmd_hi,
    input  logic [SW-1:0]      src_sel,
    input  logic [N*ID_W-1:0]  agent_phys_id,
    input  logic [N*ID_W-1:0]  agent_log_id,
    input  logic [N*FMT_W-1:0] agent_fmt,
    input  logic [N-1:0]       agent_present,
    input  logic [N-1:0]       agent_enable,
    output logic               done,
    output logic [N-1:0]       deliver_mask,
    output logic [31:0]        cmd_echo,
    output logic [7:0]         vector,
    output logic [2:0]         dlv_mode,
    output logic               level,
    output logic               trig
);
    typedef struct packed {
        logic         done;
        logic [N-1:0] mask;
        logic [31:0]  echo;
    } out_state_t;

    shorthand_e      sh;
    logic            logical;
    logic [2:0]      mode_in;
    logic [ID_W-1:0] dest;
    logic [N-1:0]    match_w;
    logic [N-1:0]    cand_w;
    logic [N-1:0]    grant_w;
    logic            rr_fire;

    assign sh      = shorthand_e'(cmd_lo[SH_LO +: 2]);
    assign logical = cmd_lo[ADDR_BIT];
    assign mode_in = cmd_lo[MODE_LO +: 3];
    assign dest    = cmd_hi[DEST_LO +: ID_W];

    for (genvar a = 0; a < N; a++) begin : g_agent
        ida_match u_match (
            .sh      (sh),
            .logical (logical),
            .dest    (dest),
            .phys_id (agent_phys_id[a*ID_W +: ID_W]),
            .log_id  (agent_log_id[a*ID_W +: ID_W]),
            .fmt     (agent_fmt[a*FMT_W +: FMT_W]),
            .is_src  (src_sel == SW'(a)),
            .present (agent_present[a]),
            .hit     (match_w[a])
        );
    end

    assign cand_w  = match_w & agent_enable;
    assign rr_fire = cmd_valid && (mode_in == MODE_LOWEST);

    ida_rr_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (rr_fire),
        .cand  (cand_w),
        .grant (grant_w)
    );

    out_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cmd_valid) begin
            st_d.done = 1'b1;
            case (mode_in)
                MODE_FIXED:  st_d.mask = cand_w;
                MODE_LOWEST: st_d.mask = grant_w;
                default:     st_d.mask = match_w;
            endcase
            st_d.echo             = cmd_lo;
            st_d.echo[STATUS_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done         = st_q.done;
    assign deliver_mask = st_q.mask;
    assign cmd_echo     = st_q.echo;
    assign vector       = st_q.echo[7:0];
    assign dlv_mode     = st_q.echo[MODE_LO +: 3];
    assign level        = st_q.echo[LEVEL_BIT];
    assign trig         = st_q.echo[TRIG_BIT];

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid));
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(deliver_mask));
    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && sh == SH_DEST && !logical && dest == BCAST_ID)
            |-> (match_w == agent_present));
    p_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && sh == SH_ALL) |-> (match_w == agent_present));
    p_lowest_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dlv_mode == MODE_LOWEST) |-> $onehot0(deliver_mask));
    p_fixed_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && mode_in == MODE_FIXED) |=> ((deliver_mask & ~$past(agent_enable)) == '0));
    p_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_echo[STATUS_BIT] && vector == $past(cmd_lo[7:0])));
endmodule

// File: tb/sim_irq_dest_arbiter.sv
module sim_irq_dest_arbiter;
    localparam int  N      = 4;
    localparam int  SW     = 2;
    localparam time PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [31:0]       cmd_lo = '0;
    logic [31:0]       cmd_hi = '0;
    logic [SW-1:0]     src_sel = '0;
    logic [N*8-1:0]    agent_phys_id = '0;
    logic [N*8-1:0]    agent_log_id = '0;
    logic [N*2-1:0]    agent_fmt = '0;
    logic [N-1:0]      agent_present = '0;
    logic [N-1:0]      agent_enable = '0;
    logic              done;
    logic [N-1:0]      deliver_mask;
    logic [31:0]       cmd_echo;
    logic [7:0]        vector;
    logic [2:0]        dlv_mode;
    logic              level;
    logic              trig;

    int n_tests = 0;
    int n_fail  = 0;
    int rr_last = N - 1;

    logic [7:0] phys [N];
    logic [7:0] logi [N];
    logic [1:0] fmt  [N];
    logic       pres [N];
    logic       enab [N];

    always #(PERIOD/2) clk = ~clk;

    irq_dest_arbiter #(.N(N)) u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int c);
        for (int a = 0; a < N; a++) begin
            if (c == 0) begin
                phys[a] = 8'(a * 7 + 3);
                logi[a] = 8'(6 + a * 13);
                fmt[a]  = (a == 0) ? 2'd0 : (a == 3) ? 2'd2 : 2'd1;
                pres[a] = 1'b1;
                enab[a] = (a != 1);
            end else begin
                phys[a] = (a == 3) ? 8'hFE : 8'(a * 18);
                logi[a] = 8'(8'h25 + a * 8'h47);
                fmt[a]  = (a % 2 == 0) ? 2'd1 : 2'd0;
                pres[a] = (a != 2);
                enab[a] = (a != 3);
            end
            agent_phys_id[a*8 +: 8] = phys[a];
            agent_log_id[a*8 +: 8]  = logi[a];
            agent_fmt[a*2 +: 2]     = fmt[a];
            agent_present[a]        = pres[a];
            agent_enable[a]         = enab[a];
        end
    endtask

    function automatic bit exp_match(int a, logic [31:0] lo, logic [7:0] d, int src);
        int  shv;
        bit  r;
        shv = int'(lo[19:18]);
        if (shv == 1)      r = (a == src);
        else if (shv == 2) r = 1'b1;
        else if (shv == 3) r = (a != src);
        else if (!lo[11])  r = (d == 8'hFF) || (d == phys[a]);
        else if (fmt[a] == 2'd0) r = (logi[a] & d) != 8'h00;
        else if (fmt[a] == 2'd1)
            r = (logi[a][7:4] == d[7:4]) && ((logi[a][3:0] & d[3:0]) != 4'h0);
        else r = 1'b0;
        return r && pres[a];
    endfunction

    task automatic run_cmd(input logic [31:0] lo, input logic [7:0] d, input int src);
        logic [N-1:0] m, exp;
        int  mode;
        bit  got;
        mode = int'(lo[10:8]);
        for (int a = 0; a < N; a++) m[a] = exp_match(a, lo, d, src);
        exp = '0;
        if (mode == 0) begin
            for (int a = 0; a < N; a++) exp[a] = m[a] && enab[a];
        end else if (mode == 1) begin
            got = 1'b0;
            for (int k = 1; k <= N; k++) begin
                int idx;
                idx = (rr_last + k) % N;
                if (!got && m[idx] && enab[idx]) begin
                    got = 1'b1;
                    exp[idx] = 1'b1;
                    rr_last = idx;
                end
            end
        end else begin
            exp = m;
        end
        @(negedge clk);
        cmd_lo    = lo;
        cmd_hi    = {d, 24'h0};
        src_sel   = SW'(src);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (mode == 1)      check(deliver_mask == exp, "R8/R9 lowest", 32'(deliver_mask), 32'(exp));
        else if (mode == 0) check(deliver_mask == exp, "R7 fixed R3 R4 R5 R6", 32'(deliver_mask), 32'(exp));
        else                check(deliver_mask == exp, "R10 other mode", 32'(deliver_mask), 32'(exp));
        check(done && cmd_echo == (lo & ~32'h1000) && vector == lo[7:0] &&
              dlv_mode == lo[10:8] && level == lo[14] && trig == lo[15],
              "R11 echo", cmd_echo, lo & ~32'h1000);
        if (d == 8'h00) begin
            @(negedge clk);
            check(!done && deliver_mask == exp, "R2 pulse", {31'h0, done}, 32'h0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        load_cfg(0);
        repeat (3) @(negedge clk);
        check(!done && deliver_mask == '0, "R1 reset", {27'h0, deliver_mask, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && deliver_mask == '0, "R1 idle", {27'h0, deliver_mask, done}, 32'h0);
        for (int c = 0; c < 2; c++) begin
            load_cfg(c);
            for (int s = 0; s < 2; s++) begin
                for (int am = 0; am < 2; am++) begin
                    for (int sh = 0; sh < 4; sh++) begin
                        for (int mi = 0; mi < 3; mi++) begin
                            for (int d = 0; d < 256; d++) begin
                                logic [31:0] lo;
                                logic [2:0]  md;
                                md = (mi == 2) ? 3'd4 : 3'(mi);
                                lo = '0;
                                lo[7:0]   = 8'(d) ^ 8'h5A;
                                lo[10:8]  = md;
                                lo[11]    = am[0];
                                lo[12]    = d[0];
                                lo[14]    = d[1];
                                lo[15]    = d[2];
                                lo[19:18] = 2'(sh);
                                run_cmd(lo, 8'(d), s * 3);
                            end
                        end
                    end
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule